// File: doc/BRIEF.md
# Cycle-Stealing Block Transfer Engine

This block copies a run of words between one peripheral and system memory while the processor keeps running. Software sets up four values through a small register port: which way the words travel, the peripheral's address, the first memory address, and how many words to move. It then writes a start bit. For every word the engine first waits until the peripheral signals that it is ready. It then asks for the shared system bus and waits for the grant. It performs exactly one memory read or memory write and gives the bus back before it handles the next word.

Each word costs the processor a single stolen bus cycle. The memory pointer advances by one and the remaining count drops by one after every word. When the count reaches zero the engine raises an interrupt. The interrupt stays high until software clears it. A job programmed with a count of zero finishes at once with no bus traffic.

Top module: `dma_steal_ctrl`

## Requirements
- R1: After reset, bus_req, bus_rd, bus_wr, per_ack and irq are low, and the status register (address 4) reads busy (bit 0) = 0 and irq (bit 1) = 0.
- R2: The registers for peripheral address (address 1), memory address (address 2) and word count (address 3) read back the last value written while idle. Bit 1 of the control register (address 0) reads back the direction; bit 0 of the control register always reads 0.
- R3: With direction 0 (peripheral to memory) and count N, a start moves N peripheral words in order into memory locations start, start+1, ..., start+N-1. No other location is written.
- R4: With direction 1 (memory to peripheral) and count N, the peripheral receives the contents of memory locations start .. start+N-1 in order. It receives word i with per_wdata in the cycle where per_ack is high.
- R5: bus_rd or bus_wr is high only while bus_grant and bus_req are both high, and never both at once.
- R6: In the cycle after any bus read or write, bus_req is low, so the processor can regain the bus between words.
- R7: Each word uses exactly one bus cycle, so a job of N words shows exactly N cycles with bus_rd or bus_wr, and exactly N per_ack pulses, each one clock long.
- R8: While busy (status bit 0 = 1), writes to the control, peripheral address, memory address and count registers are ignored, and a further start has no effect.
- R9: irq rises on the same edge at which busy falls, after the last word. It stays high until software writes the status register with bit 1 set. Writing status with bit 1 clear leaves it high.
- R10: A start with a count of 0 raises irq two clock edges after the start write, with no bus request.
- R11: Throughout a job, per_addr shows the programmed peripheral address whenever per_ack is high.
- R12: While per_req stays low, the engine does not raise bus_req.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 3 | Register select: 0 control, 1 peripheral address, 2 memory address, 3 count, 4 status |
| cfg_wdata | input | DW | Register write data |
| cfg_rdata | output | DW | Register read data for cfg_addr |
| per_req | input | 1 | Peripheral ready to give or take one word |
| per_rdata | input | DW | Word offered by the peripheral |
| per_ack | output | 1 | One-cycle pulse closing each word with the peripheral |
| per_addr | output | PW | Programmed peripheral address |
| per_wdata | output | DW | Word sent to the peripheral, valid with per_ack |
| bus_req | output | 1 | System bus request |
| bus_grant | input | 1 | System bus grant |
| bus_addr | output | AW | Memory address of the bus cycle |
| bus_rd | output | 1 | Memory read strobe |
| bus_wr | output | 1 | Memory write strobe |
| bus_wdata | output | DW | Memory write data |
| bus_rdata | input | DW | Memory read data |
| irq | output | 1 | Job-complete interrupt |

## Verification
Suppose the pointer or remaining count drifts. Then memory locations one past the block change, or the peripheral sees words out of order, or the number of bus cycles and acknowledges differs from the count. All of these show up as soon as the job ends. If the sequencer lingers in or skips a bus state, the result shows on the next word as a bus strobe without a grant or a request that stays high after a strobe. If the busy flag or the parameter registers are wrong, a register read during the job, or the interrupt timing of a zero-length job, shows it within two cycles.

// File: rtl/dma_steal_pkg.sv
package dma_steal_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WAIT_DEV,
        ST_REQ,
        ST_CYCLE,
        ST_GAP,
        ST_DONE
    } eng_state_e;

    typedef enum logic {
        DIR_DEV2MEM = 1'b0,
        DIR_MEM2DEV = 1'b1
    } dir_e;

    localparam logic [2:0] RA_CTRL = 3'd0;
    localparam logic [2:0] RA_DEV  = 3'd1;
    localparam logic [2:0] RA_MEM  = 3'd2;
    localparam logic [2:0] RA_CNT  = 3'd3;
    localparam logic [2:0] RA_STAT = 3'd4;

    localparam int CTRL_START_BIT = 0;
    localparam int CTRL_DIR_BIT   = 1;
    localparam int STAT_BUSY_BIT  = 0;
    localparam int STAT_IRQ_BIT   = 1;

    // Zero-extending placement of a narrow field into a register word.
    function automatic logic [63:0] widen(input logic [63:0] v);
        return v;
    endfunction

endpackage

// File: rtl/dma_regfile.sv
module dma_regfile
    import dma_steal_pkg::*;
#(
    parameter int RW = 16,
    parameter int AW = 16,
    parameter int CW = 16,
    parameter int PW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          cfg_we,
    input  logic [2:0]    cfg_addr,
    input  logic [RW-1:0] cfg_wdata,
    output logic [RW-1:0] cfg_rdata,
    input  logic          busy,
    input  logic          done,
    output logic          start,
    output dir_e          dir,
    output logic [PW-1:0] dev_addr,
    output logic [AW-1:0] mem_addr,
    output logic [CW-1:0] word_cnt,
    output logic          irq
);

    logic wr_ctrl, wr_stat, irq_clear;

    assign wr_ctrl   = cfg_we && (cfg_addr == RA_CTRL);
    assign wr_stat   = cfg_we && (cfg_addr == RA_STAT);
    assign irq_clear = wr_stat && cfg_wdata[STAT_IRQ_BIT];
    assign start     = wr_ctrl && cfg_wdata[CTRL_START_BIT] && !busy;

    always_ff @(posedge clk) begin
        if (rst) begin
            dir      <= DIR_DEV2MEM;
            dev_addr <= '0;
            mem_addr <= '0;
            word_cnt <= '0;
            irq      <= 1'b0;
        end else begin
            if (cfg_we && !busy) begin
                case (cfg_addr)
                    RA_CTRL: dir      <= dir_e'(cfg_wdata[CTRL_DIR_BIT]);
                    RA_DEV:  dev_addr <= cfg_wdata[PW-1:0];
                    RA_MEM:  mem_addr <= cfg_wdata[AW-1:0];
                    RA_CNT:  word_cnt <= cfg_wdata[CW-1:0];
                    default: ;
                endcase
            end
            if (done)
                irq <= 1'b1;
            else if (irq_clear)
                irq <= 1'b0;
        end
    end

    always_comb begin
        cfg_rdata = '0;
        case (cfg_addr)
            RA_CTRL: cfg_rdata[CTRL_DIR_BIT] = dir;
            RA_DEV:  cfg_rdata[PW-1:0]       = dev_addr;
            RA_MEM:  cfg_rdata[AW-1:0]       = mem_addr;
            RA_CNT:  cfg_rdata[CW-1:0]       = word_cnt;
            RA_STAT: begin
                cfg_rdata[STAT_BUSY_BIT] = busy;
                cfg_rdata[STAT_IRQ_BIT]  = irq;
            end
            default: cfg_rdata = '0;
        endcase
    end

    // R8: parameters cannot move while a job runs
    p_param_hold_r8: assert property (@(posedge clk) disable iff (rst)
        busy |=> ($stable(mem_addr) && $stable(word_cnt) && $stable(dev_addr) && $stable(dir)));

    // R9: interrupt only falls through an explicit clear
    p_irq_hold_r9: assert property (@(posedge clk) disable iff (rst)
        (irq && !irq_clear) |=> irq);

endmodule

// File: rtl/dma_path.sv
module dma_path #(
    parameter int DW = 16,
    parameter int AW = 16,
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [AW-1:0] load_addr,
    input  logic [CW-1:0] load_cnt,
    input  logic          cap_dev,
    input  logic [DW-1:0] dev_word,
    input  logic          cap_bus,
    input  logic [DW-1:0] bus_word,
    input  logic          step,
    output logic [AW-1:0] addr_q,
    output logic [DW-1:0] data_q,
    output logic          cnt_zero
);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            addr_q <= '0;
            cnt_q  <= '0;
        end else if (load) begin
            addr_q <= load_addr;
            cnt_q  <= load_cnt;
        end else if (step) begin
            addr_q <= addr_q + AW'(1);
            cnt_q  <= cnt_q - CW'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            data_q <= '0;
        else if (cap_dev)
            data_q <= dev_word;
        else if (cap_bus)
            data_q <= bus_word;
    end

    assign cnt_zero = (cnt_q == '0);

    // R3: a word is never moved when nothing remains
    p_no_underflow_r3: assert property (@(posedge clk) disable iff (rst)
        step |-> !cnt_zero);

    p_single_capture_r4: assert property (@(posedge clk) disable iff (rst)
        !(cap_dev && cap_bus));

endmodule

// File: rtl/dma_seq.sv
module dma_seq
    import dma_steal_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic start,
    input  dir_e dir_in,
    input  logic zero_len,
    input  logic per_req,
    input  logic bus_grant,
    input  logic cnt_zero,
    output logic load,
    output logic cap_dev,
    output logic cap_bus,
    output logic step,
    output logic bus_req,
    output logic bus_rd,
    output logic bus_wr,
    output logic per_ack,
    output logic busy,
    output logic done
);

    eng_state_e state, state_nx;
    dir_e       dir_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
            dir_q <= DIR_DEV2MEM;
        end else begin
            state <= state_nx;
            if (load) dir_q <= dir_in;
        end
    end

    always_comb begin
        state_nx = state;
        case (state)
            ST_IDLE:     if (start) state_nx = zero_len ? ST_DONE : ST_WAIT_DEV;
            ST_WAIT_DEV: if (per_req) state_nx = ST_REQ;
            ST_REQ:      if (bus_grant) state_nx = ST_CYCLE;
            ST_CYCLE:    state_nx = ST_GAP;
            ST_GAP:      state_nx = cnt_zero ? ST_DONE : ST_WAIT_DEV;
            ST_DONE:     state_nx = ST_IDLE;
            default:     state_nx = ST_IDLE;
        endcase
    end

    assign load    = (state == ST_IDLE) && start;
    assign cap_dev = (state == ST_WAIT_DEV) && per_req && (dir_q == DIR_DEV2MEM);
    assign bus_req = (state == ST_REQ) || (state == ST_CYCLE);
    assign bus_rd  = (state == ST_CYCLE) && (dir_q == DIR_MEM2DEV);
    assign bus_wr  = (state == ST_CYCLE) && (dir_q == DIR_DEV2MEM);
    assign cap_bus = bus_rd;
    assign step    = (state == ST_CYCLE);
    assign per_ack = (state == ST_GAP);
    assign busy    = (state != ST_IDLE);
    assign done    = (state == ST_DONE);

    // R5: strobes only under a held grant, never both
    p_one_cmd_r5: assert property (@(posedge clk) disable iff (rst)
        !(bus_rd && bus_wr));
    p_cyc_granted_r5: assert property (@(posedge clk) disable iff (rst)
        (bus_rd || bus_wr) |-> (bus_grant && bus_req));
    // R6: bus released right after each word
    p_gap_r6: assert property (@(posedge clk) disable iff (rst)
        (bus_rd || bus_wr) |=> !bus_req);
    // R7: acknowledge is a single-cycle pulse
    p_ack_pulse_r7: assert property (@(posedge clk) disable iff (rst)
        per_ack |=> !per_ack);
    // R9: completion leaves the engine idle
    p_done_idle_r9: assert property (@(posedge clk) disable iff (rst)
        done |=> !busy);
    // R12: no request unless the peripheral asked
    p_wait_dev_r12: assert property (@(posedge clk) disable iff (rst)
        (state == ST_WAIT_DEV && !per_req) |=> !bus_req);

endmodule

// File: rtl/dma_steal_ctrl.sv
module dma_steal_ctrl
    import dma_steal_pkg::*;
#(
    parameter int DW = 16,
    parameter int AW = 16,
    parameter int CW = 16,
    parameter int PW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          cfg_we,
    input  logic [2:0]    cfg_addr,
    input  logic [DW-1:0] cfg_wdata,
    output logic [DW-1:0] cfg_rdata,
    input  logic          per_req,
    input  logic [DW-1:0] per_rdata,
    output logic          per_ack,
    output logic [PW-1:0] per_addr,
    output logic [DW-1:0] per_wdata,
    output logic          bus_req,
    input  logic          bus_grant,
    output logic [AW-1:0] bus_addr,
    output logic          bus_rd,
    output logic          bus_wr,
    output logic [DW-1:0] bus_wdata,
    input  logic [DW-1:0] bus_rdata,
    output logic          irq
);

    logic          start, busy, done;
    dir_e          dir;
    logic [AW-1:0] mem_addr;
    logic [CW-1:0] word_cnt;
    logic          load, cap_dev, cap_bus, step, cnt_zero;
    logic [AW-1:0] addr_q;
    logic [DW-1:0] data_q;

    dma_regfile #(.RW(DW), .AW(AW), .CW(CW), .PW(PW)) u_regs (
        .clk(clk), .rst(rst),
        .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .busy(busy), .done(done), .start(start), .dir(dir),
        .dev_addr(per_addr), .mem_addr(mem_addr), .word_cnt(word_cnt), .irq(irq)
    );

    dma_seq u_seq (
        .clk(clk), .rst(rst),
        .start(start), .dir_in(dir), .zero_len(word_cnt == '0),
        .per_req(per_req), .bus_grant(bus_grant), .cnt_zero(cnt_zero),
        .load(load), .cap_dev(cap_dev), .cap_bus(cap_bus), .step(step),
        .bus_req(bus_req), .bus_rd(bus_rd), .bus_wr(bus_wr),
        .per_ack(per_ack), .busy(busy), .done(done)
    );

    dma_path #(.DW(DW), .AW(AW), .CW(CW)) u_path (
        .clk(clk), .rst(rst),
        .load(load), .load_addr(mem_addr), .load_cnt(word_cnt),
        .cap_dev(cap_dev), .dev_word(per_rdata),
        .cap_bus(cap_bus), .bus_word(bus_rdata),
        .step(step),
        .addr_q(addr_q), .data_q(data_q), .cnt_zero(cnt_zero)
    );

    assign bus_addr  = addr_q;
    assign bus_wdata = data_q;
    assign per_wdata = data_q;

endmodule

// File: tb/dma_steal_ctrl_test.sv
module dma_steal_ctrl_test;
    import dma_steal_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int DW = 16;
    localparam int AW = 16;
    localparam int CW = 16;
    localparam int PW = 8;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          cfg_we = 1'b0;
    logic [2:0]    cfg_addr = '0;
    logic [DW-1:0] cfg_wdata = '0;
    logic [DW-1:0] cfg_rdata;
    logic          per_req = 1'b0;
    logic [DW-1:0] per_rdata;
    logic          per_ack;
    logic [PW-1:0] per_addr;
    logic [DW-1:0] per_wdata;
    logic          bus_req;
    logic          bus_grant = 1'b0;
    logic [AW-1:0] bus_addr;
    logic          bus_rd, bus_wr;
    logic [DW-1:0] bus_wdata;
    logic [DW-1:0] bus_rdata;
    logic          irq;

    always #(CLK_PERIOD/2) clk = ~clk;

    dma_steal_ctrl #(.DW(DW), .AW(AW), .CW(CW), .PW(PW)) uut (.*);

    int total = 0;
    int bad = 0;

    // bench-side models
    logic [DW-1:0] mem [0:255];
    logic [DW-1:0] sink [0:63];
    logic          pre_we = 1'b0;
    logic [7:0]    pre_a = '0;
    logic [DW-1:0] pre_d = '0;
    logic          dev_clr = 1'b0;
    logic          dev_hold = 1'b0;
    int            dev_idx = 0;
    int            seed = 0;
    logic [PW-1:0] exp_dev = '0;
    logic          ctr_clr = 1'b0;
    int            cyc_n = 0, ack_n = 0, gap_bad = 0, gnt_bad = 0, dev_bad = 0;
    logic          prev_cyc = 1'b0;
    int            wd = 0;

    function automatic logic [DW-1:0] dev_word(int s, int i);
        return DW'(s * 37 + i * 113 + 5) ^ 16'hA5C3;
    endfunction

    function automatic logic [DW-1:0] mem_word(int s, int i);
        return DW'(s * 91 + i * 29 + 17) ^ 16'h3C5A;
    endfunction

    assign per_rdata = dev_word(seed, dev_idx);
    assign bus_rdata = bus_rd ? mem[bus_addr[7:0]] : '0;

    always @(posedge clk) begin
        if (pre_we) mem[pre_a] <= pre_d;
        else if (bus_wr) mem[bus_addr[7:0]] <= bus_wdata;
    end

    always @(posedge clk) begin
        if (dev_clr) dev_idx <= 0;
        else if (per_ack) begin
            if (dev_idx < 64) sink[dev_idx] <= per_wdata;
            dev_idx <= dev_idx + 1;
        end
        per_req <= dev_hold ? 1'b0 : (($urandom % 4) != 0);
        if (rst) bus_grant <= 1'b0;
        else bus_grant <= bus_req && (bus_grant || (($urandom % 3) == 0));
    end

    always @(posedge clk) begin
        if (ctr_clr) begin
            cyc_n <= 0; ack_n <= 0; gap_bad <= 0; gnt_bad <= 0; dev_bad <= 0;
            prev_cyc <= 1'b0;
        end else if (!rst) begin
            if (prev_cyc && bus_req) gap_bad <= gap_bad + 1;
            if ((bus_rd || bus_wr) && !(bus_grant && bus_req)) gnt_bad <= gnt_bad + 1;
            if (bus_rd && bus_wr) gnt_bad <= gnt_bad + 1;
            if (per_ack && per_addr != exp_dev) dev_bad <= dev_bad + 1;
            if (bus_rd || bus_wr) cyc_n <= cyc_n + 1;
            if (per_ack) ack_n <= ack_n + 1;
            prev_cyc <= bus_rd || bus_wr;
        end
    end

    always @(posedge clk) begin
        wd <= wd + 1;
        if (wd > 150000) begin
            $display("FAIL watchdog expired act=%0d exp=<150000", wd);
            $display("  test done: total=%0d bad=%0d", total + 1, bad + 1);
            $finish;
        end
    end

    task automatic chk(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%0h exp=%0h", req, act, exp);
        end
    endtask

    task automatic wr_reg(input logic [2:0] a, input logic [DW-1:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic rd_reg(input logic [2:0] a, output logic [DW-1:0] d);
        cfg_addr = a;
        #1;
        d = cfg_rdata;
    endtask

    task automatic preload(input int base, input int n, input int s, input logic [DW-1:0] mark);
        for (int i = 0; i <= n; i++) begin
            @(negedge clk);
            pre_we = 1'b1;
            pre_a = 8'(base + i);
            pre_d = (i == n) ? mark : mem_word(s, i);
        end
        @(negedge clk);
        pre_we = 1'b0;
    endtask

    task automatic wait_irq(input string req);
        int n = 0;
        while (!irq && n < 5000) begin
            @(negedge clk);
            n++;
        end
        chk(irq, req, 32'(irq), 32'd1);
    endtask

    task automatic run_job(input logic d, input logic [PW-1:0] dv, input int ma, input int len, input logic protect);
        logic [DW-1:0] r;
        logic [DW-1:0] mark;
        mark = DW'(16'hBEEF ^ len);
        seed = seed + 1;
        preload(ma, len, seed, mark);
        @(negedge clk);
        dev_clr = 1'b1; ctr_clr = 1'b1;
        @(negedge clk);
        dev_clr = 1'b0; ctr_clr = 1'b0;
        exp_dev = dv;
        wr_reg(RA_DEV, DW'(dv));
        wr_reg(RA_MEM, DW'(ma));
        wr_reg(RA_CNT, DW'(len));
        wr_reg(RA_CTRL, DW'({d, 1'b0}));
        rd_reg(RA_CTRL, r);
        chk(r == DW'({d, 1'b0}), "R2 ctrl readback", 32'(r), 32'({d, 1'b0}));
        rd_reg(RA_MEM, r);
        chk(r == DW'(ma), "R2 mem readback", 32'(r), 32'(ma));
        wr_reg(RA_CTRL, DW'({d, 1'b1}));
        if (protect) begin
            rd_reg(RA_STAT, r);
            chk(r[STAT_BUSY_BIT] == 1'b1, "R8 busy after start", 32'(r), 32'h1);
            wr_reg(RA_MEM, DW'(ma + 50));
            wr_reg(RA_CNT, DW'(len + 3));
            wr_reg(RA_CTRL, DW'({~d, 1'b1}));
            rd_reg(RA_MEM, r);
            chk(r == DW'(ma), "R8 mem held", 32'(r), 32'(ma));
            rd_reg(RA_CNT, r);
            chk(r == DW'(len), "R8 cnt held", 32'(r), 32'(len));
            rd_reg(RA_CTRL, r);
            chk(r[CTRL_DIR_BIT] == d, "R8 dir held", 32'(r), 32'(d));
        end
        wait_irq("R9 irq at end");
        rd_reg(RA_STAT, r);
        chk(r[STAT_BUSY_BIT] == 1'b0, "R9 busy clear with irq", 32'(r), 32'h2);
        chk(cyc_n == len, "R7 bus cycle count", 32'(cyc_n), 32'(len));
        chk(ack_n == len, "R7 ack count", 32'(ack_n), 32'(len));
        chk(gap_bad == 0, "R6 release between words", 32'(gap_bad), 32'd0);
        chk(gnt_bad == 0, "R5 strobe under grant", 32'(gnt_bad), 32'd0);
        chk(dev_bad == 0, "R11 per_addr", 32'(dev_bad), 32'd0);
        if (d == 1'b0) begin
            for (int i = 0; i < len; i++)
                chk(mem[8'(ma + i)] == dev_word(seed, i), "R3 word stored",
                    32'(mem[8'(ma + i)]), 32'(dev_word(seed, i)));
            chk(mem[8'(ma + len)] == mark, "R3 no write past block", 32'(mem[8'(ma + len)]), 32'(mark));
        end else begin
            for (int i = 0; i < len; i++)
                chk(sink[i] == mem_word(seed, i), "R4 word delivered",
                    32'(sink[i]), 32'(mem_word(seed, i)));
        end
        wr_reg(RA_STAT, DW'(1 << STAT_IRQ_BIT));
        @(negedge clk);
    endtask

    initial begin
        logic [DW-1:0] r;
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(!bus_req && !bus_rd && !bus_wr && !per_ack && !irq, "R1 outputs idle",
            32'({bus_req, bus_rd, bus_wr, per_ack, irq}), 32'd0);
        rd_reg(RA_STAT, r);
        chk(r == '0, "R1 status idle", 32'(r), 32'd0);
        wr_reg(RA_DEV, 16'h005A);
        rd_reg(RA_DEV, r);
        chk(r == 16'h005A, "R2 dev readback", 32'(r), 32'h5A);
        wr_reg(RA_CNT, 16'h1234);
        rd_reg(RA_CNT, r);
        chk(r == 16'h1234, "R2 cnt readback", 32'(r), 32'h1234);

        // directed jobs
        run_job(1'b0, 8'h11, 10, 5, 1'b1);
        run_job(1'b1, 8'h22, 40, 7, 1'b1);
        run_job(1'b0, 8'h33, 250, 1, 1'b0);
        run_job(1'b1, 8'h44, 252, 9, 1'b0);

        // R9: irq holds until explicit clear
        run_job(1'b0, 8'h55, 100, 3, 1'b0);
        wr_reg(RA_CNT, 16'd2);
        wr_reg(RA_CTRL, 16'h0001);
        wait_irq("R9 irq raised");
        repeat (5) @(negedge clk);
        chk(irq, "R9 irq holds", 32'(irq), 32'd1);
        wr_reg(RA_STAT, 16'h0001);
        chk(irq, "R9 irq holds after write without clear bit", 32'(irq), 32'd1);
        wr_reg(RA_STAT, 16'h0002);
        chk(!irq, "R9 irq cleared", 32'(irq), 32'd0);

        // R10: zero-length job
        @(negedge clk);
        ctr_clr = 1'b1;
        @(negedge clk);
        ctr_clr = 1'b0;
        wr_reg(RA_CNT, 16'd0);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = RA_CTRL; cfg_wdata = 16'h0001;
        @(negedge clk);
        cfg_we = 1'b0;
        chk(!irq, "R10 irq not yet after first edge", 32'(irq), 32'd0);
        @(negedge clk);
        chk(irq, "R10 irq after second edge", 32'(irq), 32'd1);
        rd_reg(RA_STAT, r);
        chk(r == 16'h0002, "R10 status idle with irq", 32'(r), 32'h2);
        chk(cyc_n == 0 && !bus_req, "R10 no bus traffic", 32'(cyc_n), 32'd0);
        wr_reg(RA_STAT, 16'h0002);

        // R12: peripheral not ready holds off the bus request
        dev_hold = 1'b1;
        @(negedge clk);
        ctr_clr = 1'b1;
        @(negedge clk);
        ctr_clr = 1'b0;
        dev_clr = 1'b1;
        @(negedge clk);
        dev_clr = 1'b0;
        exp_dev = 8'h55;
        wr_reg(RA_CNT, 16'd2);
        wr_reg(RA_CTRL, 16'h0001);
        begin
            int seen = 0;
            for (int i = 0; i < 20; i++) begin
                @(negedge clk);
                if (bus_req) seen++;
            end
            chk(seen == 0, "R12 no request while peripheral idle", 32'(seen), 32'd0);
        end
        dev_hold = 1'b0;
        wait_irq("R12 job finishes after release");
        chk(cyc_n == 2, "R12 two words after release", 32'(cyc_n), 32'd2);
        wr_reg(RA_STAT, 16'h0002);

        // constrained random jobs
        for (int k = 0; k < 8; k++) begin
            logic           rd_dir;
            logic [PW-1:0]  rdev;
            int             rma, rlen;
            rd_dir = 1'($urandom % 2);
            rdev   = PW'($urandom);
            rma    = int'($urandom % 200);
            rlen   = 1 + int'($urandom % 40);
            run_job(rd_dir, rdev, rma, rlen, 1'($urandom % 2));
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule